// File: doc/BRIEF.md
# Push-Button Press Qualifier

This block takes the raw, bouncing level of a mechanical push-button and turns each genuine press into a single pulse one clock wide. The raw level first passes through a synchroniser. A hold counter then advances on every clock edge at which the synchronised level is high, and it returns to zero on any edge at which that level is low. When the count reaches its top value, a terminal-count compare fires. An edge detector converts that condition into a one-cycle strobe.

A press is accepted only after the synchronised level has stayed high for `HOLD_CYCLES-1` consecutive edges. The counter then parks at its top value, so holding the button down never produces a second strobe. The default `HOLD_CYCLES` of 50,000,000 gives about half a second of qualification at 100 MHz. Simulation uses a small value such as 6.

Top module: `press_pulse_filter`

## Requirements
- R1: The raw input crosses `SYNC_STAGES` (default 2) flip-flops before reaching the counter. With `HOLD_CYCLES`=6, a level raised before clock edge 1 and held produces its strobe in the cycle that follows edge 7.
- R2: The counter clears on every edge at which the synchronised level is low. A low glitch therefore restarts qualification: two highs of 3 edges separated by 1 low edge give no strobe.
- R3: With `HOLD_CYCLES`=6, a raw high lasting 5 or more clock edges gives a strobe, and a high lasting 1 to 4 edges gives none.
- R4: Every strobe is exactly one clock cycle wide.
- R5: The counter saturates at `HOLD_CYCLES-1`. A press held for any length of time gives exactly one strobe.
- R6: A second qualifying press after a release gives a second strobe, even when the release lasts only one edge.
- R7: While `rst_n` is low (active-low, asynchronous) the strobe is 0, and the synchroniser and counter are cleared. After release, a held input needs a full fresh qualification: the strobe comes 7 cycles after the release edge when `HOLD_CYCLES`=6.
- R8: The counter is `max(1, ceil(log2(HOLD_CYCLES)))` bits wide. Elaboration rejects `HOLD_CYCLES` below 2 and `SYNC_STAGES` below 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of synchroniser and counter |
| btn_raw | input | 1 | Raw, unsynchronised button level |
| press_stb | output | 1 | One-cycle strobe per qualified press |

## Verification
The assertions check the following on every cycle:
- the counter returns to zero after a low sample;
- the counter steps by exactly one while the level is high;
- the counter stays parked at its top value;
- a strobe never lasts past one cycle;
- a strobe appears only at the terminal count;
- the strobe is quiet during reset.

Only the bench's scenarios can show the end-to-end press-length threshold, the seven-cycle latency through the synchroniser, glitch restart, back-to-back presses and the fresh qualification after a reset.

// File: rtl/press_pulse_filter_pkg.sv
package press_pulse_filter_pkg;
   // Width of a counter that must hold values 0 .. n-1, at least one bit.
   function automatic int unsigned cnt_width(input longint unsigned n);
      int unsigned w;
      w = 1;
      while ((longint'(1) << w) < n) w++;
      return w;
   endfunction
endpackage

// File: rtl/ppf_sync.sv
// Multi-stage synchroniser for the asynchronous button level.
module ppf_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ppf_hold_counter.sv
// Saturating hold counter: counts edges with level high, clears on low.
module ppf_hold_counter #(
   parameter longint unsigned HOLD = 6,
   parameter int unsigned     W    = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         level,
   output logic [W-1:0] count,
   output logic         at_top
);
   localparam logic [W-1:0] TOP = W'(HOLD - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             count <= '0;
      else if (!level)        count <= '0;
      else if (count != TOP)  count <= count + 1'b1;
   end

   // terminal-count comparator, purely combinational
   assign at_top = (count == TOP);

   p_clear_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !level |=> count == '0);
   p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (level && count != TOP) |=> count == $past(count) + 1'b1);
   p_park_at_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (level && count == TOP) |=> count == TOP);
   p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      count <= TOP);
endmodule

// File: rtl/ppf_edge_strobe.sv
// Rising-edge detector on the terminal-count flag; history flop has no reset.
module ppf_edge_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   output logic stb
);
   logic flag_q;

   always_ff @(posedge clk)
      flag_q <= flag;

   assign stb = flag & ~flag_q;

   p_one_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> !stb);
endmodule

// File: rtl/press_pulse_filter.sv
module press_pulse_filter #(
   parameter longint unsigned HOLD_CYCLES = 50_000_000,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_raw,
   output logic press_stb
);
   import press_pulse_filter_pkg::*;

   localparam int unsigned CW = cnt_width(HOLD_CYCLES);
   localparam logic [CW-1:0] TOP = CW'(HOLD_CYCLES - 1);

   generate
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         $error("press_pulse_filter: HOLD_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("press_pulse_filter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          lvl;
   logic [CW-1:0] cnt;
   logic          top;

   ppf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (btn_raw),
      .q_sync  (lvl)
   );

   ppf_hold_counter #(.HOLD(HOLD_CYCLES), .W(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .level  (lvl),
      .count  (cnt),
      .at_top (top)
   );

   ppf_edge_strobe u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .flag  (top),
      .stb   (press_stb)
   );

   p_strobe_at_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      press_stb |-> cnt == TOP);
   p_strobe_needs_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      press_stb |-> $past(lvl));
   p_quiet_in_reset_r7: assert property (@(posedge clk)
      !rst_n |-> !press_stb);
endmodule

// File: tb/press_pulse_filter_bench.sv
module press_pulse_filter_bench;
   localparam int NV = 8;
   // raw high length (edges), expected strobe count, expected first-strobe sample
   localparam int V_LEN [NV] = '{1, 2, 3, 4, 5, 6, 20, 50};
   localparam int V_EXP [NV] = '{0, 0, 0, 0, 1, 1, 1, 1};
   localparam int V_LAT [NV] = '{0, 0, 0, 0, 7, 7, 7, 7};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn = 1'b0;
   logic stb;
   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   press_pulse_filter #(.HOLD_CYCLES(6), .SYNC_STAGES(2)) u_press_pulse_filter (
      .clk(clk), .rst_n(rst_n), .btn_raw(btn), .press_stb(stb)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive high for hi edges then low for lo edges; sample strobe on negedges.
   task automatic press(input int hi, input int lo,
                        output int n_hi, output int n_rise, output int first);
      int prev = 0;
      n_hi = 0; n_rise = 0; first = 0;
      btn = 1'b1;
      for (int i = 1; i <= hi + lo; i++) begin
         @(negedge clk);
         if (stb) begin
            n_hi++;
            if (prev == 0) n_rise++;
            if (first == 0) first = i;
         end
         prev = int'(stb);
         if (i == hi) btn = 1'b0;
      end
   endtask

   initial begin
      #(200000 * 20);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int nh, nr, fi, nh2, nr2, fi2;
      // R7: reset state
      repeat (3) @(negedge clk);
      check("R7 strobe low in reset", int'(stb), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R7 strobe low after reset", int'(stb), 0);

      // R3 R4 R5 R1: table walk
      for (int v = 0; v < NV; v++) begin
         press(V_LEN[v], 12, nh, nr, fi);
         check($sformatf("R3 R5 strobes for len %0d", V_LEN[v]), nr, V_EXP[v]);
         check($sformatf("R4 width for len %0d", V_LEN[v]), nh, nr);
         if (V_EXP[v] != 0)
            check($sformatf("R1 latency for len %0d", V_LEN[v]), fi, V_LAT[v]);
      end

      // R2: glitch restarts qualification (3 high, 1 low, 3 high)
      press(3, 1, nh, nr, fi);
      press(3, 12, nh2, nr2, fi2);
      check("R2 glitch gives no strobe", nr + nr2, 0);

      // R6: two presses separated by a one-edge release
      press(10, 1, nh, nr, fi);
      press(10, 12, nh2, nr2, fi2);
      check("R6 first press strobe", nr, 1);
      check("R6 second press strobe", nr2, 1);
      check("R6 second press latency", fi2, 7);

      // R7: reset mid-press, input held; needs full fresh qualification
      btn = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R7 strobe low in mid-press reset", int'(stb), 0);
      rst_n = 1'b1;
      press(20, 12, nh, nr, fi);
      check("R7 one strobe after reset release", nr, 1);
      check("R7 fresh qualification latency", fi, 7);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule